// File: doc/BRIEF.md
# Sequencer-to-Host Circular Push Queue

This block lets a message sequence engine hand words to a host processor through shared RAM. The engine issues a push command that names a source. The source can be the captured time tag, the status word of the latest message, an immediate operand, or the word held at a RAM address the command supplies. The block performs the RAM access and stores the word at the location named by a pointer register. It then advances that pointer around a 64-word ring that sits inside an aligned block of the address space.

The host can read the pointer at any time and can load it to choose the ring's base. When a store fills the ring's last slot and the pointer returns to slot 0, the block raises a rollover pulse if that pulse is enabled. It also sets a sticky flag, which the host clears by writing 1. The block has no read side and no occupancy flags.

Top module: `seq_push_queue`

## Requirements
- R1: After reset the pointer reads 0, push_ready is 1, and mem_req, push_done, rollover_irq and rollover_sts are all 0.
- R2: A push is accepted only on a clock edge where push_ready and push_valid are both 1. push_ready stays 0 from the edge after acceptance until the cycle in which push_done is high. A request held during that time causes no extra RAM write.
- R3: Source code 00 stores the time_tag value seen at acceptance, 01 stores blk_status seen at acceptance, and 10 stores push_operand. The store cycle (mem_req=1, mem_we=1, mem_addr equal to the pointer) is the cycle right after acceptance.
- R4: Source code 11 first spends one read cycle (mem_req=1, mem_we=0, mem_addr equal to push_operand). It then spends one store cycle that writes the word mem_rdata returned for that read, one cycle after the read, at the pointer.
- R5: push_done is a one-cycle pulse in the cycle after the store cycle. That is 2 cycles after acceptance for a direct source and 3 cycles for source 11.
- R6: Each store increments the low 6 bits of the pointer modulo 64 and leaves the upper 10 bits unchanged.
- R7: A store at a pointer whose low 6 bits are 63 produces a one-cycle rollover_irq pulse, in the same cycle as push_done, when int_enable is 1. No pulse occurs when int_enable is 0.
- R8: rollover_sts is set by every wrap whatever the state of int_enable. It stays set until host_sts_clr is 1 on a clock edge, and a wrap on that same edge keeps it set.
- R9: host_ptr_wr loads the pointer with host_ptr_wdata on the next edge. It takes priority over a store's increment on the same edge and suppresses that edge's wrap indication, and the store still goes to the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request from the sequence engine |
| push_src | input | 2 | Source select: 00 time tag, 01 status word, 10 immediate, 11 memory |
| push_operand | input | 16 | Immediate word, or RAM address for source 11 |
| push_ready | output | 1 | Block idle and able to accept a push |
| push_done | output | 1 | Pulse after the store completes |
| time_tag | input | 16 | Free-running time tag value |
| blk_status | input | 16 | Status word of the latest message |
| host_ptr_wr | input | 1 | Host load strobe for the pointer |
| host_ptr_wdata | input | 16 | Pointer value written by the host |
| host_ptr_rdata | output | 16 | Current pointer (next slot to write) |
| host_sts_clr | input | 1 | Write-1 clear of the sticky rollover flag |
| int_enable | input | 1 | Rollover pulse enable |
| rollover_irq | output | 1 | One-cycle rollover interrupt pulse |
| rollover_sts | output | 1 | Sticky rollover flag |
| mem_req | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write (1) or read (0) |
| mem_addr | output | 16 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, valid the cycle after a read |

## Verification
The assertions assume a RAM with a fixed one-cycle read latency, so mem_rdata carries the fetched word in the cycle after a read strobe. They also assume that push_valid is only taken as a request while push_ready is high. The bench's RAM model registers read data on the read edge and returns a word computed from the address. The bench raises requests only at idle points, except in the one test that deliberately holds a request through a busy period. Host pointer loads and flag clears are driven between edges, one at a time, at the points where the tests expect them.

// File: rtl/spq_pkg.sv
package spq_pkg;
  typedef enum logic [1:0] {
    SRC_TTAG = 2'b00,
    SRC_BSW  = 2'b01,
    SRC_IMM  = 2'b10,
    SRC_MEM  = 2'b11
  } spq_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } spq_state_e;
endpackage

// File: rtl/spq_seq.sv
module spq_seq
  import spq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [1:0]    push_src,
  input  logic [DW-1:0] push_operand,
  input  logic [DW-1:0] time_tag,
  input  logic [DW-1:0] blk_status,
  input  logic [DW-1:0] mem_rdata,
  output logic          push_ready,
  output logic          fetch_cyc,
  output logic          store_fire,
  output logic [AW-1:0] fetch_addr,
  output logic [DW-1:0] store_word,
  output logic          push_done
);
  spq_state_e state_q;
  spq_src_e   src_q;
  logic [DW-1:0] word_q;
  logic          done_q;

  // Word captured at acceptance; for memory pushes it holds the read address.
  function automatic logic [DW-1:0] pick_source(spq_src_e s, logic [DW-1:0] op,
                                                logic [DW-1:0] tt, logic [DW-1:0] bsw);
    case (s)
      SRC_TTAG: pick_source = tt;
      SRC_BSW:  pick_source = bsw;
      default:  pick_source = op;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_TTAG;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (push_valid) begin
            src_q   <= spq_src_e'(push_src);
            word_q  <= pick_source(spq_src_e'(push_src), push_operand, time_tag, blk_status);
            state_q <= (spq_src_e'(push_src) == SRC_MEM) ? ST_FETCH : ST_STORE;
          end
        end
        ST_FETCH: state_q <= ST_STORE;
        ST_STORE: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign push_ready = (state_q == ST_IDLE);
  assign fetch_cyc  = (state_q == ST_FETCH);
  assign store_fire = (state_q == ST_STORE);
  assign fetch_addr = word_q[AW-1:0];
  assign store_word = (src_q == SRC_MEM) ? mem_rdata : word_q;
  assign push_done  = done_q;
endmodule

// File: rtl/spq_ptr.sv
module spq_ptr #(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_wdata,
  input  logic          step,
  output logic [AW-1:0] ptr_q,
  output logic          wrap_evt
);
  localparam logic [QW-1:0] SLOT_LAST = {QW{1'b1}};
  localparam logic [QW-1:0] SLOT_ONE  = {{(QW-1){1'b0}}, 1'b1};

  // Advance within the aligned block: only the low QW bits count.
  function automatic logic [AW-1:0] ptr_bump(logic [AW-1:0] p);
    logic [QW-1:0] lo;
    lo = p[QW-1:0] + SLOT_ONE;
    ptr_bump = {p[AW-1:QW], lo};
  endfunction

  function automatic logic at_last(logic [AW-1:0] p);
    at_last = (p[QW-1:0] == SLOT_LAST);
  endfunction

  assign wrap_evt = step && !host_wr && at_last(ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (host_wr) ptr_q <= host_wdata;
    else if (step)    ptr_q <= ptr_bump(ptr_q);
  end
endmodule

// File: rtl/spq_irq.sv
module spq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic int_enable,
  input  logic sts_clr,
  output logic irq_q,
  output logic sts_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      irq_q <= wrap_evt && int_enable;
      if (wrap_evt)     sts_q <= 1'b1;
      else if (sts_clr) sts_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_push_queue.sv
module seq_push_queue #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [1:0]    push_src,
  input  logic [DW-1:0] push_operand,
  output logic          push_ready,
  output logic          push_done,
  input  logic [DW-1:0] time_tag,
  input  logic [DW-1:0] blk_status,
  input  logic          host_ptr_wr,
  input  logic [AW-1:0] host_ptr_wdata,
  output logic [AW-1:0] host_ptr_rdata,
  input  logic          host_sts_clr,
  input  logic          int_enable,
  output logic          rollover_irq,
  output logic          rollover_sts,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic          fetch_cyc;
  logic          store_fire;
  logic          wrap_evt;
  logic [AW-1:0] fetch_addr;
  logic [AW-1:0] ptr_q;

  spq_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_src(push_src), .push_operand(push_operand),
    .time_tag(time_tag), .blk_status(blk_status), .mem_rdata(mem_rdata),
    .push_ready(push_ready), .fetch_cyc(fetch_cyc), .store_fire(store_fire),
    .fetch_addr(fetch_addr), .store_word(mem_wdata), .push_done(push_done)
  );

  spq_ptr #(.AW(AW), .QW(QW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_ptr_wr), .host_wdata(host_ptr_wdata),
    .step(store_fire), .ptr_q(ptr_q), .wrap_evt(wrap_evt)
  );

  spq_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .wrap_evt(wrap_evt), .int_enable(int_enable), .sts_clr(host_sts_clr),
    .irq_q(rollover_irq), .sts_q(rollover_sts)
  );

  assign host_ptr_rdata = ptr_q;
  assign mem_req        = fetch_cyc || store_fire;
  assign mem_we         = store_fire;
  assign mem_addr       = fetch_cyc ? fetch_addr : ptr_q;
endmodule

// File: rtl/spq_checker.sv
module spq_checker #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int QW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_ready,
  input logic          push_done,
  input logic          host_ptr_wr,
  input logic [AW-1:0] host_ptr_wdata,
  input logic [AW-1:0] host_ptr_rdata,
  input logic          int_enable,
  input logic          rollover_irq,
  input logic          rollover_sts,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          store_fire,
  input logic          wrap_evt
);
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !push_ready);

  a_r3_store_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == host_ptr_rdata));

  a_r4_read_then_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_req && mem_we));

  a_r5_done_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |-> $past(mem_req && mem_we));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> !push_done);

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && !host_ptr_wr) |=>
      (host_ptr_rdata[AW-1:QW] == $past(host_ptr_rdata[AW-1:QW])) &&
      (host_ptr_rdata[QW-1:0] == QW'($past(host_ptr_rdata[QW-1:0]) + 1'b1)));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rollover_irq |-> $past(wrap_evt && int_enable && mem_we && (mem_addr[QW-1:0] == {QW{1'b1}})));

  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> rollover_sts);

  a_r9_host_load: assert property (@(posedge clk) disable iff (!rst_n)
    host_ptr_wr |=> (host_ptr_rdata == $past(host_ptr_wdata)));

  a_r9_load_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    host_ptr_wr |-> !wrap_evt);

  a_r6_data_known: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !$isunknown(mem_wdata));
endmodule

bind seq_push_queue spq_checker #(.DW(DW), .AW(AW), .QW(QW)) u_spq_chk (
  .clk(clk), .rst_n(rst_n), .push_ready(push_ready), .push_done(push_done),
  .host_ptr_wr(host_ptr_wr), .host_ptr_wdata(host_ptr_wdata),
  .host_ptr_rdata(host_ptr_rdata), .int_enable(int_enable),
  .rollover_irq(rollover_irq), .rollover_sts(rollover_sts),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .store_fire(store_fire), .wrap_evt(wrap_evt)
);

// File: tb/tb_seq_push_queue.sv
module tb_seq_push_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [1:0]  push_src = 2'b00;
  logic [15:0] push_operand = '0;
  logic        push_ready, push_done;
  logic [15:0] time_tag = '0, blk_status = '0;
  logic        host_ptr_wr = 1'b0;
  logic [15:0] host_ptr_wdata = '0;
  logic [15:0] host_ptr_rdata;
  logic        host_sts_clr = 1'b0;
  logic        int_enable = 1'b0;
  logic        rollover_irq, rollover_sts;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  int nchk = 0;
  int nerr = 0;

  logic [15:0] last_wa = '0, last_wd = '0;
  int wr_count = 0;

  always #10 clk = ~clk;

  seq_push_queue dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_src(push_src),
    .push_operand(push_operand), .push_ready(push_ready), .push_done(push_done),
    .time_tag(time_tag), .blk_status(blk_status), .host_ptr_wr(host_ptr_wr),
    .host_ptr_wdata(host_ptr_wdata), .host_ptr_rdata(host_ptr_rdata),
    .host_sts_clr(host_sts_clr), .int_enable(int_enable),
    .rollover_irq(rollover_irq), .rollover_sts(rollover_sts),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model: one-cycle read latency, content derived from the address.
  function automatic logic [15:0] ram_word(logic [15:0] a);
    return a ^ 16'hA5C3;
  endfunction

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      last_wa  <= mem_addr;
      last_wd  <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    if (mem_req && !mem_we) mem_rdata <= ram_word(mem_addr);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // Issue one push, then count negedges until push_done; report irq seen at done.
  task automatic do_push(input logic [1:0] s, input logic [15:0] op, input logic [15:0] tt,
                         input logic [15:0] bs, output int lat, output logic irq_at_done);
    @(negedge clk);
    push_valid = 1'b1; push_src = s; push_operand = op; time_tag = tt; blk_status = bs;
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0; time_tag = ~tt; blk_status = ~bs;
    lat = 1;
    while (!push_done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    irq_at_done = rollover_irq;
  endtask

  task automatic host_load(input logic [15:0] v);
    @(negedge clk);
    host_ptr_wr = 1'b1; host_ptr_wdata = v;
    @(negedge clk);
    host_ptr_wr = 1'b0;
  endtask

  // {src, operand, time_tag, blk_status}
  localparam logic [49:0] VEC [0:5] = '{
    {2'b00, 16'h1111, 16'h5A01, 16'h0BB0},
    {2'b01, 16'h2222, 16'h5A02, 16'h8001},
    {2'b10, 16'hABCD, 16'h5A03, 16'h0BB3},
    {2'b11, 16'h0031, 16'h5A04, 16'h0BB4},
    {2'b10, 16'h0000, 16'h5A05, 16'h0BB5},
    {2'b11, 16'h03FF, 16'h5A06, 16'h0BB6}
  };

  initial begin
    int lat;
    logic irq;
    int wc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(host_ptr_rdata == 16'h0, "R1 ptr", host_ptr_rdata, 0);
    check(push_ready == 1'b1, "R1 ready", push_ready, 1);
    check(mem_req == 1'b0 && push_done == 1'b0, "R1 idle bus", {mem_req, push_done}, 0);
    check(rollover_irq == 1'b0 && rollover_sts == 1'b0, "R1 irq", {rollover_irq, rollover_sts}, 0);
    rst_n = 1'b1;

    // Table walk: R3, R4, R5, R6
    for (int i = 0; i < 6; i++) begin
      logic [1:0]  s;
      logic [15:0] op, tt, bs, exp;
      {s, op, tt, bs} = VEC[i];
      case (s)
        2'b00:   exp = tt;
        2'b01:   exp = bs;
        2'b10:   exp = op;
        default: exp = ram_word(op);
      endcase
      do_push(s, op, tt, bs, lat, irq);
      check(last_wd == exp, (s == 2'b11) ? "R4 data" : "R3 data", last_wd, exp);
      check(last_wa == 16'(i), "R3 addr", last_wa, i);
      check(lat == ((s == 2'b11) ? 3 : 2), "R5 latency", lat, (s == 2'b11) ? 3 : 2);
      check(host_ptr_rdata == 16'(i + 1), "R6 ptr step", host_ptr_rdata, i + 1);
    end
    @(negedge clk);
    check(push_done == 1'b0, "R5 pulse width", push_done, 0);

    // R2: request held high through a busy store is not taken twice
    wc = wr_count;
    @(negedge clk);
    push_valid = 1'b1; push_src = 2'b10; push_operand = 16'h7777;
    @(posedge clk);
    @(negedge clk);
    check(push_ready == 1'b0, "R2 ready low while busy", push_ready, 0);
    @(negedge clk);
    check(push_done == 1'b1 && push_ready == 1'b1, "R2 ready back at done", {push_done, push_ready}, 2'b11);
    push_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(wr_count == wc + 1, "R2 single write", wr_count, wc + 1);

    // R7, R6, R8: wrap with pulse enabled in an aligned block
    int_enable = 1'b1;
    host_load(16'h1A3E);
    check(host_ptr_rdata == 16'h1A3E, "R9 host load", host_ptr_rdata, 16'h1A3E);
    do_push(2'b10, 16'h0E01, 16'h0, 16'h0, lat, irq);
    check(irq == 1'b0, "R7 no pulse before last slot", irq, 0);
    do_push(2'b10, 16'h0E02, 16'h0, 16'h0, lat, irq);
    check(last_wa == 16'h1A3F, "R7 last slot addr", last_wa, 16'h1A3F);
    check(irq == 1'b1, "R7 pulse at wrap", irq, 1);
    check(host_ptr_rdata == 16'h1A00, "R6 wrap keeps base", host_ptr_rdata, 16'h1A00);
    check(rollover_sts == 1'b1, "R8 sticky set", rollover_sts, 1);
    @(negedge clk);
    check(rollover_irq == 1'b0, "R7 pulse one cycle", rollover_irq, 0);
    check(rollover_sts == 1'b1, "R8 sticky holds", rollover_sts, 1);
    host_sts_clr = 1'b1;
    @(negedge clk);
    host_sts_clr = 1'b0;
    check(rollover_sts == 1'b0, "R8 clear", rollover_sts, 0);

    // R7, R8: wrap with pulse disabled still sets sticky
    int_enable = 1'b0;
    host_load(16'h0C3F);
    do_push(2'b00, 16'h0, 16'h4444, 16'h0, lat, irq);
    check(irq == 1'b0, "R7 masked", irq, 0);
    check(rollover_sts == 1'b1, "R8 set while masked", rollover_sts, 1);
    check(host_ptr_rdata == 16'h0C00, "R6 wrap masked", host_ptr_rdata, 16'h0C00);
    host_sts_clr = 1'b1;
    @(negedge clk);
    host_sts_clr = 1'b0;

    // R9: host load in the store cycle wins and cancels the wrap
    int_enable = 1'b1;
    host_load(16'h043F);
    @(negedge clk);
    push_valid = 1'b1; push_src = 2'b10; push_operand = 16'h9999;
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    host_ptr_wr = 1'b1; host_ptr_wdata = 16'h0810;
    @(negedge clk);
    host_ptr_wr = 1'b0;
    check(last_wa == 16'h043F && last_wd == 16'h9999, "R9 store at old ptr", last_wa, 16'h043F);
    check(host_ptr_rdata == 16'h0810, "R9 load wins", host_ptr_rdata, 16'h0810);
    check(rollover_irq == 1'b0, "R9 no pulse", rollover_irq, 0);
    check(rollover_sts == 1'b0, "R9 no sticky", rollover_sts, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule